// File: doc/BRIEF.md
# Memory Operand Linear Address Generator

This block turns the decoded parts of a memory operand into a 64-bit linear address. It takes a base register value, an index register value with a scale code, a short or long displacement, an optional wide direct offset, a segment base, the current code mode and an address-size override flag. It sums the offset parts, cuts the sum down to the effective address size, zero-extends it, and then adds the segment base at full width.

Requests enter through a valid/ready pair and the address leaves one cycle later from a register, also under valid/ready. A two-state output slot controls the flow. `ST_EMPTY` holds nothing. `ST_FULL` holds an address that has not yet been taken. The transitions are named as follows:
- **load** (`ST_EMPTY` to `ST_FULL`): a request is accepted.
- **refill** (`ST_FULL` to `ST_FULL`): the held address is taken and a new request is accepted in the same cycle.
- **hold** (`ST_FULL` to `ST_FULL`): the held address is not taken.
- **drain** (`ST_FULL` to `ST_EMPTY`): the held address is taken and no request arrives.

While the slot is empty it simply stays empty.

Top module: `ea_gen_unit`

## Requirements
- R1: With `disp_wide`=0, bits [7:0] of `disp_val` are sign-extended to 64 bits. With `disp_wide`=1, all 32 bits are sign-extended to 64 bits.
- R2: The offset is base + (index << scale) + displacement. Scale codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8. When `base_en` is 0 the base counts as zero, and when `index_en` is 0 the index counts as zero.
- R3: The `mode` code 0 means 16-bit code, 1 means 32-bit and 2 means 64-bit; code 3 is treated as 64-bit. Without the override, the effective address size is 16, 32 or 64 bits respectively.
- R4: With `addr_ovr`=1 the effective size changes as follows: 16-bit code uses 32 bits, 32-bit code uses 16 bits, and 64-bit code uses 32 bits. In 16-bit code this means the full 32-bit base value takes part.
- R5: The offset is truncated to the effective size and zero-extended to 64 bits before the segment base is added, so carries out of the effective size are lost.
- R6: The segment base is added at 64-bit width, and the result wraps modulo 2^64.
- R7: With `direct_en`=1, `direct_off` replaces base, index and displacement. It is truncated only to the effective size, so in 64-bit code without the override all 64 bits pass.
- R8: A request is accepted on a clock edge when `req_valid` and `req_ready` are both 1. Its address appears on `out_addr` with `out_valid`=1 after that edge. `req_ready` is 1 when the slot is empty or `out_ready` is 1. When the address is taken with no new request, `out_valid` falls.
- R9: While `out_valid`=1 and `out_ready`=0, `out_addr` stays unchanged, `req_ready` is 0 and a request that is presented is not accepted.
- R10: During and after reset, `out_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| mode | input | 2 | Code mode: 0 = 16-bit, 1 = 32-bit, 2 or 3 = 64-bit |
| addr_ovr | input | 1 | Address-size override |
| base_en | input | 1 | Base register present |
| base_val | input | 64 | Base register value |
| index_en | input | 1 | Index register present |
| index_val | input | 64 | Index register value |
| scale | input | 2 | Index shift amount, 0 to 3 |
| disp_val | input | 32 | Displacement; only bits [7:0] are used when short |
| disp_wide | input | 1 | 1 = 32-bit displacement, 0 = 8-bit |
| direct_en | input | 1 | Use the direct offset instead of the sum |
| direct_off | input | 64 | Direct offset value |
| seg_base | input | 64 | Segment base |
| out_valid | output | 1 | Address held |
| out_ready | input | 1 | Downstream takes the address |
| out_addr | output | 64 | Linear address |

## Verification
A wrong slot state shows up at the ports within one cycle. It appears either as a request lost or repeated on the valid/ready pair, or as `out_addr` moving while it is stalled. Errors in size selection and truncation show only in the address bits above the effective size, or in a carry that should have been dropped. The vectors therefore place sums on the 16-bit and 32-bit boundaries in every mode with and without the override, and the results are read one cycle after acceptance. The segment wrap is covered separately, and so is the case where the direct offset bypasses the displacement path.

// File: rtl/ea_pkg.sv
package ea_pkg;
    typedef enum logic [1:0] {
        CM_16 = 2'd0,
        CM_32 = 2'd1,
        CM_64 = 2'd2,
        CM_RSV = 2'd3
    } cmode_e;

    typedef enum logic [1:0] {
        AS_16 = 2'd0,
        AS_32 = 2'd1,
        AS_64 = 2'd2
    } asize_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } slot_e;
endpackage

// File: rtl/ea_size_sel.sv
module ea_size_sel
    import ea_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       addr_ovr,
    output asize_e     asz
);
    cmode_e cm;
    assign cm = cmode_e'(mode);

    // R3 defaults, R4 override mapping
    always_comb begin
        unique case (cm)
            CM_16:   asz = addr_ovr ? AS_32 : AS_16;
            CM_32:   asz = addr_ovr ? AS_16 : AS_32;
            default: asz = addr_ovr ? AS_32 : AS_64;
        endcase
    end
endmodule

// File: rtl/ea_offset_calc.sv
module ea_offset_calc
    import ea_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int DISP_W  = 32,
    parameter int SDISP_W = 8
) (
    input  logic              base_en,
    input  logic [ADDR_W-1:0] base_val,
    input  logic              index_en,
    input  logic [ADDR_W-1:0] index_val,
    input  logic [1:0]        scale,
    input  logic [DISP_W-1:0] disp_val,
    input  logic              disp_wide,
    input  logic              direct_en,
    input  logic [ADDR_W-1:0] direct_off,
    input  asize_e            asz,
    output logic [ADDR_W-1:0] off
);
    localparam int NARROW_W = 16;
    localparam int MID_W    = 32;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] base_term;
    logic [ADDR_W-1:0] idx_term;
    logic [ADDR_W-1:0] raw_sum;

    // R1: sign extension of short or long displacement
    always_comb begin
        if (disp_wide)
            disp_ext = {{(ADDR_W-DISP_W){disp_val[DISP_W-1]}}, disp_val};
        else
            disp_ext = {{(ADDR_W-SDISP_W){disp_val[SDISP_W-1]}}, disp_val[SDISP_W-1:0]};
    end

    // R2: missing parts count as zero, index shifted by scale
    assign base_term = base_en  ? base_val : '0;
    assign idx_term  = index_en ? (index_val << scale) : '0;

    // R7: direct offset bypasses the sum
    assign raw_sum = direct_en ? direct_off : (base_term + idx_term + disp_ext);

    // R5: truncate to effective size, then zero-extend
    always_comb begin
        unique case (asz)
            AS_16:   off = {{(ADDR_W-NARROW_W){1'b0}}, raw_sum[NARROW_W-1:0]};
            AS_32:   off = {{(ADDR_W-MID_W){1'b0}}, raw_sum[MID_W-1:0]};
            default: off = raw_sum;
        endcase
    end

    always_comb begin
        if (asz == AS_16)
            a_r5_zero_ext_16: assert (off[ADDR_W-1:NARROW_W] == '0);
        if (asz == AS_32)
            a_r5_zero_ext_32: assert (off[ADDR_W-1:MID_W] == '0);
    end
endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
    import ea_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int DISP_W  = 32,
    parameter int SDISP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        mode,
    input  logic              addr_ovr,
    input  logic              base_en,
    input  logic [ADDR_W-1:0] base_val,
    input  logic              index_en,
    input  logic [ADDR_W-1:0] index_val,
    input  logic [1:0]        scale,
    input  logic [DISP_W-1:0] disp_val,
    input  logic              disp_wide,
    input  logic              direct_en,
    input  logic [ADDR_W-1:0] direct_off,
    input  logic [ADDR_W-1:0] seg_base,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr
);
    asize_e            asz;
    logic [ADDR_W-1:0] eff_off;
    logic [ADDR_W-1:0] lin_addr;
    logic              accept;
    slot_e             state, state_nx;

    ea_size_sel u_size (
        .mode     (mode),
        .addr_ovr (addr_ovr),
        .asz      (asz)
    );

    ea_offset_calc #(
        .ADDR_W  (ADDR_W),
        .DISP_W  (DISP_W),
        .SDISP_W (SDISP_W)
    ) u_off (
        .base_en    (base_en),
        .base_val   (base_val),
        .index_en   (index_en),
        .index_val  (index_val),
        .scale      (scale),
        .disp_val   (disp_val),
        .disp_wide  (disp_wide),
        .direct_en  (direct_en),
        .direct_off (direct_off),
        .asz        (asz),
        .off        (eff_off)
    );

    // R6: full-width segment add, wraps modulo 2^ADDR_W
    assign lin_addr = eff_off + seg_base;

    assign req_ready = (state == ST_EMPTY) || out_ready;
    assign accept    = req_valid && req_ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (accept) state_nx = ST_FULL;
            ST_FULL:  if (out_ready && !accept) state_nx = ST_EMPTY;
            default:  state_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      out_addr <= '0;
        else if (accept) out_addr <= lin_addr;
    end

    assign out_valid = (state == ST_FULL);

    a_r8_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> out_valid);

    a_r8_drain_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !req_valid) |=> !out_valid);

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

    a_r7_direct_full: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && direct_en && mode == 2'd2 && !addr_ovr && seg_base == '0)
        |=> (out_addr == $past(direct_off)));
endmodule

// File: tb/tb_ea_gen_unit.sv
`timescale 1ns/1ps
module tb_ea_gen_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready;
    logic [1:0]  mode;
    logic        addr_ovr, base_en, index_en, disp_wide, direct_en;
    logic [63:0] base_val, index_val, direct_off, seg_base, out_addr;
    logic [1:0]  scale;
    logic [31:0] disp_val;
    logic        out_valid, out_ready;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ea_gen_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .mode(mode), .addr_ovr(addr_ovr), .base_en(base_en), .base_val(base_val),
        .index_en(index_en), .index_val(index_val), .scale(scale),
        .disp_val(disp_val), .disp_wide(disp_wide), .direct_en(direct_en),
        .direct_off(direct_off), .seg_base(seg_base), .out_valid(out_valid),
        .out_ready(out_ready), .out_addr(out_addr)
    );

    typedef struct packed {
        logic [15:0] tag;
        logic [1:0]  md;
        logic        ovr;
        logic        ben;
        logic [63:0] bv;
        logic        ien;
        logic [63:0] iv;
        logic [1:0]  sc;
        logic [31:0] dv;
        logic        dw;
        logic        den;
        logic [63:0] doff;
        logic [63:0] seg;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VT [NV] = '{
        '{"R1", 2'd2, 1'b0, 1'b1, 64'h1000, 1'b1, 64'h10, 2'd3, 32'h0000_00F0, 1'b0, 1'b0, 64'h0, 64'h0, 64'h1070},
        '{"R1", 2'd2, 1'b0, 1'b1, 64'h1_0000_0000, 1'b0, 64'h0, 2'd0, 32'h8000_0000, 1'b1, 1'b0, 64'h0, 64'h10, 64'h8000_0010},
        '{"R5", 2'd1, 1'b0, 1'b1, 64'hFFFF_FFF0, 1'b0, 64'h0, 2'd0, 32'h20, 1'b0, 1'b0, 64'h0, 64'h1_0000_0000, 64'h1_0000_0010},
        '{"R3", 2'd0, 1'b0, 1'b1, 64'h1_FFFF, 1'b0, 64'h0, 2'd0, 32'h02, 1'b0, 1'b0, 64'h0, 64'h2_0000, 64'h2_0001},
        '{"R4", 2'd0, 1'b1, 1'b1, 64'h1_FFFF, 1'b0, 64'h0, 2'd0, 32'h02, 1'b0, 1'b0, 64'h0, 64'h0, 64'h2_0001},
        '{"R4", 2'd1, 1'b1, 1'b1, 64'h1234_5678, 1'b1, 64'h2, 2'd1, 32'h0, 1'b0, 1'b0, 64'h0, 64'h0, 64'h567C},
        '{"R4", 2'd2, 1'b1, 1'b1, 64'hFFFF_FFFF_0000_0100, 1'b0, 64'h0, 2'd0, 32'h0, 1'b0, 1'b0, 64'h0, 64'h5000, 64'h5100},
        '{"R7", 2'd2, 1'b0, 1'b1, 64'h999, 1'b1, 64'h7, 2'd2, 32'h44, 1'b1, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h10, 64'h1234_5678_9ABC_DF00},
        '{"R7", 2'd2, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0, 2'd0, 32'h0, 1'b0, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h0, 64'h9ABC_DEF0},
        '{"R6", 2'd2, 1'b0, 1'b1, 64'h20, 1'b0, 64'h0, 2'd0, 32'h0, 1'b0, 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h10},
        '{"R2", 2'd2, 1'b0, 1'b0, 64'hDEAD, 1'b0, 64'h55, 2'd3, 32'h100, 1'b1, 1'b0, 64'h0, 64'h0, 64'h100},
        '{"R2", 2'd3, 1'b0, 1'b1, 64'h0, 1'b1, 64'h3, 2'd2, 32'h7F, 1'b0, 1'b0, 64'h0, 64'h0, 64'h8B},
        '{"R1", 2'd1, 1'b0, 1'b1, 64'h10, 1'b0, 64'h0, 2'd0, 32'h80, 1'b0, 1'b0, 64'h0, 64'h0, 64'hFFFF_FF90}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        mode = v.md; addr_ovr = v.ovr; base_en = v.ben; base_val = v.bv;
        index_en = v.ien; index_val = v.iv; scale = v.sc; disp_val = v.dv;
        disp_wide = v.dw; direct_en = v.den; direct_off = v.doff; seg_base = v.seg;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; out_ready = 1'b1;
        drive(VT[0]);
        repeat (3) @(negedge clk);
        check("R10", {63'd0, out_valid}, 64'd0);
        check("R10", {63'd0, req_ready}, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", {63'd0, out_valid}, 64'd0);

        // back-to-back vector walk
        for (int i = 0; i < NV; i++) begin
            drive(VT[i]);
            req_valid = 1'b1;
            @(negedge clk);
            check($sformatf("%s vec%0d", VT[i].tag, i), out_addr, VT[i].exp);
            check("R8", {63'd0, out_valid}, 64'd1);
        end
        req_valid = 1'b0;
        @(negedge clk);
        check("R8", {63'd0, out_valid}, 64'd0);

        // R9: stall holds the address and refuses a new request
        drive(VT[3]);
        req_valid = 1'b1;
        out_ready = 1'b0;
        @(negedge clk);
        check("R9", out_addr, VT[3].exp);
        check("R9", {63'd0, req_ready}, 64'd0);
        drive(VT[9]);
        repeat (3) @(negedge clk);
        check("R9", out_addr, VT[3].exp);
        check("R9", {63'd0, out_valid}, 64'd1);
        // release: refill takes the waiting request
        out_ready = 1'b1;
        @(negedge clk);
        check("R8", out_addr, VT[9].exp);
        req_valid = 1'b0;
        @(negedge clk);
        check("R8", {63'd0, out_valid}, 64'd0);
        check("R8", {63'd0, req_ready}, 64'd1);

        finish_run();
    end
endmodule